// File: doc/BRIEF.md
# Warp Engine Command Token Parser

This block sits in front of a geometric warp engine. It takes one stream of 32-bit command tokens over a valid/ready handshake. The stream mixes two kinds of token. A configure token writes one register of a 32-entry configuration file and stands alone. Data tokens are gathered into a job, and the job's length and layout depend on the processing mode held in that same configuration file. When a job is complete, the parser presents one job descriptor on a second valid/ready handshake. In scaling mode the descriptor carries the three unpacked scale fields. In quadrilateral mode it carries the four corner points. In both modes it also carries the source and destination addresses, the interpolation kind, the scan direction and the run flag.

Token format. Bit 31 selects the kind: 1 means configure and 0 means data. Bit 30 is a run flag that the parser carries along and never acts on. On a configure token, bits 29:25 are the register index and bits 24:0 are the value written. On a data token, bits 29:0 are the data value, because the register index has no meaning there.

A configure token that arrives partway through a job is still applied. It also discards the partial job and raises a sticky protocol-error output. The whole configuration file is driven out in parallel so that the engine can use its other settings.

Top module: `wtp_token_parser`

## Requirements
- R1: A token accepted with bit 31 = 1 writes its bits 24:0 to the register selected by bits 29:25. The new value appears on `cfg_q` one cycle after acceptance, and the token does not produce a job.
- R2: After reset, every configuration register is zero, `job_valid` and `proto_err` are 0, and `tok_ready` is 1.
- R3: When register 26 bit 0 is 0 (scaling), a job is three data tokens in this order: scale word, source address, destination address. The scale word gives `job_frx` from bits 9:0, `job_ipx` from bits 15:10 and `job_fry` from bits 25:16. `job_quad` is 0 and all corner outputs are zero.
- R4: When register 26 bit 0 is 1 (quadrilateral), a job is ten data tokens in this order: X then Y of corners 0, 1, 2 and 3, then the source address, then the destination address. `job_quad` is 1 and the three scale fields are zero.
- R5: The job layout is fixed by register 26 bit 0 as it stands when the job's first data token is accepted.
- R6: `job_interp` carries register 24 bits 1:0 (0 nearest, 1 bilinear, 2 bicubic, 3 table). `job_scan` carries register 25 bit 0. `job_crun` carries bit 30 of the job's first data token.
- R7: A configure token accepted while a job is partly gathered is applied and raises `proto_err`. The partial job is dropped, and the next data token starts a new job.
- R8: `job_valid` rises one cycle after the job's last data token is accepted. It then stays high with all descriptor fields unchanged until `job_ready` is seen. `tok_ready` is low for the whole time `job_valid` is high.
- R9: `proto_err` stays high until reset once it is set. A configure token accepted between jobs does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Parser can take a token |
| tok_data | input | 32 | Command token |
| job_valid | output | 1 | Descriptor present |
| job_ready | input | 1 | Downstream takes the descriptor |
| job_quad | output | 1 | 1 = quadrilateral job, 0 = scaling job |
| job_crun | output | 1 | Run flag of the job's first data token |
| job_interp | output | 2 | Interpolation kind |
| job_scan | output | 1 | Scan direction |
| job_frx | output | 10 | Horizontal scale fraction |
| job_ipx | output | 6 | Horizontal integer step |
| job_fry | output | 10 | Vertical scale fraction |
| job_cx | output | 4x30 | Corner X values, index = corner |
| job_cy | output | 4x30 | Corner Y values, index = corner |
| job_src | output | 30 | Source address |
| job_dst | output | 30 | Destination address |
| proto_err | output | 1 | Sticky protocol-error flag |
| cfg_q | output | 32x25 | All configuration registers |

## Verification
The assertions assume that the token source holds `tok_data` steady while `tok_valid` is high and the token has not yet been taken. They also assume that no token is offered before reset is released. The bench drives each token for exactly one accepted cycle and waits while `tok_ready` is low. Aborted jobs are produced only on purpose, by a configure token placed at every possible position inside a scaling job and inside a quadrilateral job. Descriptor back-pressure is exercised by withholding `job_ready` while a configure token waits at the input. The bench then confirms that the waiting token is taken only after the descriptor has been accepted.

// File: rtl/wtp_pkg.sv
// Package: shared token layout, register indices and job constants for the
// warp token parser. Assumes a fixed 32-bit token format.
package wtp_pkg;
    localparam int TOK_W    = 32;
    localparam int IDX_W    = 5;
    localparam int CFG_W    = 25;
    localparam int DVAL_W   = 30;
    localparam int NREG     = 1 << IDX_W;
    localparam int CMD_BIT  = 31;
    localparam int CRUN_BIT = 30;
    localparam int IDX_LSB  = 25;

    localparam logic [IDX_W-1:0] REG_INTERP = IDX_W'(24);
    localparam logic [IDX_W-1:0] REG_SCAN   = IDX_W'(25);
    localparam logic [IDX_W-1:0] REG_MODE   = IDX_W'(26);

    localparam int FRX_LSB = 0;
    localparam int FRX_W   = 10;
    localparam int IPX_LSB = 10;
    localparam int IPX_W   = 6;
    localparam int FRY_LSB = 16;
    localparam int FRY_W   = 10;

    localparam int CORNERS     = 4;
    localparam int COORD_SLOTS = 2 * CORNERS;
    localparam int SCALE_LEN   = 3;
    localparam int QUAD_LEN    = COORD_SLOTS + 2;
    localparam int CNT_W       = $clog2(QUAD_LEN);

    typedef enum logic [1:0] {
        INTERP_NEAREST  = 2'd0,
        INTERP_BILINEAR = 2'd1,
        INTERP_BICUBIC  = 2'd2,
        INTERP_TABLE    = 2'd3
    } interp_e;

    typedef struct packed {
        logic              cmd;
        logic              crun;
        logic [IDX_W-1:0]  idx;
        logic [CFG_W-1:0]  cfg_val;
        logic [DVAL_W-1:0] dval;
    } tok_fields_t;
endpackage

// File: rtl/wtp_token_split.sv
// Module: wtp_token_split
// Splits one raw token into its fields. Purely combinational.
// Assumes the package token layout; data value and config value overlap.
module wtp_token_split
    import wtp_pkg::*;
(
    input  logic [TOK_W-1:0] tok,
    output tok_fields_t      f
);
    // Field extraction from the raw token
    always_comb begin
        f.cmd     = tok[CMD_BIT];
        f.crun    = tok[CRUN_BIT];
        f.idx     = tok[IDX_LSB +: IDX_W];
        f.cfg_val = tok[0 +: CFG_W];
        f.dval    = tok[0 +: DVAL_W];
    end
endmodule

// File: rtl/wtp_cfg_file.sv
// Module: wtp_cfg_file
// Configuration register file with one write port and every register driven
// out in parallel. Assumes at most one write per cycle.
module wtp_cfg_file #(
    parameter int N  = 32,
    parameter int W  = 25,
    parameter int AW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_val,
    output logic [N-1:0][W-1:0] q
);
    logic [N-1:0] hit;

    // Per-register write enable decode
    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_idx == AW'(g));
    end

    // Register storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (hit[i]) q[i] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/wtp_job_collect.sv
// Module: wtp_job_collect
// Counts data tokens into a job and captures each token into its descriptor
// field. The mode is latched at the first token. A config token aborts a
// partial job. Assumes data_fire and cfg_fire are never high together.
module wtp_job_collect
    import wtp_pkg::*;
#(
    parameter int DW = DVAL_W,
    parameter int CW = CNT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      data_fire,
    input  logic                      cfg_fire,
    input  logic                      crun,
    input  logic [DW-1:0]             dval,
    input  logic                      mode_quad,
    input  logic [1:0]                interp,
    input  logic                      scan,
    output logic                      done,
    output logic                      abort,
    output logic                      quad_q,
    output logic                      crun_q,
    output interp_e                   interp_q,
    output logic                      scan_q,
    output logic [FRX_W-1:0]          frx_q,
    output logic [IPX_W-1:0]          ipx_q,
    output logic [FRY_W-1:0]          fry_q,
    output logic [CORNERS-1:0][DW-1:0] cx_q,
    output logic [CORNERS-1:0][DW-1:0] cy_q,
    output logic [DW-1:0]             src_q,
    output logic [DW-1:0]             dst_q
);
    localparam logic [CW-1:0] SCALE_LAST = CW'(SCALE_LEN - 1);
    localparam logic [CW-1:0] QUAD_LAST  = CW'(QUAD_LEN - 1);
    localparam logic [CW-1:0] QUAD_SRC   = CW'(COORD_SLOTS);
    localparam logic [CW-1:0] SC_SRC     = CW'(1);

    logic [CW-1:0] cnt;
    logic          first;
    logic          eff_quad;
    logic          last;
    logic [1:0]    corner;

    // Slot decode for the current token
    always_comb begin
        first    = (cnt == '0);
        eff_quad = first ? mode_quad : quad_q;
        last     = eff_quad ? (cnt == QUAD_LAST) : (cnt == SCALE_LAST);
        done     = data_fire && last;
        abort    = cfg_fire && !first;
        corner   = cnt[2:1];
    end

    // Sequence position counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cfg_fire)   cnt <= '0;
        else if (data_fire)  cnt <= last ? '0 : cnt + CW'(1);
    end

    // Per-job attributes latched at the first data token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quad_q <= 1'b0;
            crun_q <= 1'b0;
        end else if (data_fire && first) begin
            quad_q <= mode_quad;
            crun_q <= crun;
        end
    end

    // Interpolation kind and scan direction latched as the job completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interp_q <= INTERP_NEAREST;
            scan_q   <= 1'b0;
        end else if (done) begin
            interp_q <= interp_e'(interp);
            scan_q   <= scan;
        end
    end

    // Field capture: clear at job start, then store the token in its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frx_q <= '0;
            ipx_q <= '0;
            fry_q <= '0;
            cx_q  <= '0;
            cy_q  <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else if (data_fire) begin
            if (first) begin
                frx_q <= '0;
                ipx_q <= '0;
                fry_q <= '0;
                cx_q  <= '0;
                cy_q  <= '0;
                src_q <= '0;
                dst_q <= '0;
            end
            if (eff_quad) begin
                if (cnt < QUAD_SRC) begin
                    if (cnt[0]) cy_q[corner] <= dval;
                    else        cx_q[corner] <= dval;
                end else if (cnt == QUAD_SRC) begin
                    src_q <= dval;
                end else begin
                    dst_q <= dval;
                end
            end else begin
                if (first) begin
                    frx_q <= dval[FRX_LSB +: FRX_W];
                    ipx_q <= dval[IPX_LSB +: IPX_W];
                    fry_q <= dval[FRY_LSB +: FRY_W];
                end else if (cnt == SC_SRC) begin
                    src_q <= dval;
                end else begin
                    dst_q <= dval;
                end
            end
        end
    end
endmodule

// File: rtl/wtp_token_parser.sv
// Module: wtp_token_parser (top)
// Parses the mixed token stream into register writes and job descriptors.
// Assumes the token source holds data while valid and not yet accepted.
module wtp_token_parser
    import wtp_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tok_valid,
    output logic                           tok_ready,
    input  logic [31:0]                    tok_data,
    output logic                           job_valid,
    input  logic                           job_ready,
    output logic                           job_quad,
    output logic                           job_crun,
    output logic [1:0]                     job_interp,
    output logic                           job_scan,
    output logic [9:0]                     job_frx,
    output logic [5:0]                     job_ipx,
    output logic [9:0]                     job_fry,
    output logic [3:0][29:0]               job_cx,
    output logic [3:0][29:0]               job_cy,
    output logic [29:0]                    job_src,
    output logic [29:0]                    job_dst,
    output logic                           proto_err,
    output logic [31:0][24:0]              cfg_q
);
    tok_fields_t f;
    logic        fire;
    logic        cfg_fire;
    logic        data_fire;
    logic        done;
    logic        abort;
    interp_e     interp_q;

    wtp_token_split u_split (
        .tok (tok_data),
        .f   (f)
    );

    // Handshake qualification of the incoming token
    always_comb begin
        tok_ready = !job_valid;
        fire      = tok_valid && tok_ready;
        cfg_fire  = fire && f.cmd;
        data_fire = fire && !f.cmd;
    end

    wtp_cfg_file #(.N(NREG), .W(CFG_W), .AW(IDX_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_fire),
        .wr_idx (f.idx),
        .wr_val (f.cfg_val),
        .q      (cfg_q)
    );

    wtp_job_collect #(.DW(DVAL_W), .CW(CNT_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_fire (data_fire),
        .cfg_fire  (cfg_fire),
        .crun      (f.crun),
        .dval      (f.dval),
        .mode_quad (cfg_q[REG_MODE][0]),
        .interp    (cfg_q[REG_INTERP][1:0]),
        .scan      (cfg_q[REG_SCAN][0]),
        .done      (done),
        .abort     (abort),
        .quad_q    (job_quad),
        .crun_q    (job_crun),
        .interp_q  (interp_q),
        .scan_q    (job_scan),
        .frx_q     (job_frx),
        .ipx_q     (job_ipx),
        .fry_q     (job_fry),
        .cx_q      (job_cx),
        .cy_q      (job_cy),
        .src_q     (job_src),
        .dst_q     (job_dst)
    );

    assign job_interp = interp_q;

    // Descriptor valid: set on job completion, cleared when taken
    always_ff @(posedge clk) begin
        if (!rst_n)         job_valid <= 1'b0;
        else if (done)      job_valid <= 1'b1;
        else if (job_ready) job_valid <= 1'b0;
    end

    // Sticky protocol-error flag
    always_ff @(posedge clk) begin
        if (!rst_n)     proto_err <= 1'b0;
        else if (abort) proto_err <= 1'b1;
    end
endmodule

// File: rtl/wtp_token_parser_sva.sv
// Module: wtp_token_parser_sva
// Checker bound to the parser top. Observes ports only.
module wtp_token_parser_sva (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic              tok_ready,
    input logic [31:0]       tok_data,
    input logic              job_valid,
    input logic              job_ready,
    input logic              job_quad,
    input logic [9:0]        job_frx,
    input logic [5:0]        job_ipx,
    input logic [9:0]        job_fry,
    input logic [3:0][29:0]  job_cx,
    input logic [3:0][29:0]  job_cy,
    input logic [29:0]       job_src,
    input logic [29:0]       job_dst,
    input logic              proto_err,
    input logic [31:0][24:0] cfg_q
);
    // R1: a configure token lands in the indexed register
    p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && tok_data[31]) |=>
        (cfg_q[$past(tok_data[29:25])] == $past(tok_data[24:0])));

    // R3: scaling descriptors carry no corner values
    p_scale_no_corners_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && !job_quad) |-> (job_cx == '0 && job_cy == '0));

    // R4: quadrilateral descriptors carry no scale fields
    p_quad_no_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && job_quad) |-> (job_frx == '0 && job_ipx == '0 && job_fry == '0));

    // R7: a descriptor only follows an accepted data token
    p_job_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(job_valid) |-> $past(tok_valid && tok_ready && !tok_data[31]));

    // R8: input is stalled while a descriptor waits
    p_stall_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> !tok_ready);

    // R8: a waiting descriptor holds its contents
    p_job_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && !job_ready) |=>
        (job_valid && $stable(job_src) && $stable(job_dst) && $stable(job_cx)
         && $stable(job_cy) && $stable(job_frx) && $stable(job_quad)));

    // R9: the error flag never clears without reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind wtp_token_parser wtp_token_parser_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_data  (tok_data),
    .job_valid (job_valid),
    .job_ready (job_ready),
    .job_quad  (job_quad),
    .job_frx   (job_frx),
    .job_ipx   (job_ipx),
    .job_fry   (job_fry),
    .job_cx    (job_cx),
    .job_cy    (job_cy),
    .job_src   (job_src),
    .job_dst   (job_dst),
    .proto_err (proto_err),
    .cfg_q     (cfg_q)
);

// File: tb/wtp_token_parser_tb.sv
`timescale 1ns/1ps
module wtp_token_parser_tb;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              tok_valid;
    logic              tok_ready;
    logic [31:0]       tok_data;
    logic              job_valid;
    logic              job_ready;
    logic              job_quad;
    logic              job_crun;
    logic [1:0]        job_interp;
    logic              job_scan;
    logic [9:0]        job_frx;
    logic [5:0]        job_ipx;
    logic [9:0]        job_fry;
    logic [3:0][29:0]  job_cx;
    logic [3:0][29:0]  job_cy;
    logic [29:0]       job_src;
    logic [29:0]       job_dst;
    logic              proto_err;
    logic [31:0][24:0] cfg_q;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // expected descriptor
    logic        e_quad, e_crun, e_scan;
    logic [1:0]  e_interp;
    logic [9:0]  e_frx, e_fry;
    logic [5:0]  e_ipx;
    logic [29:0] e_cx [4];
    logic [29:0] e_cy [4];
    logic [29:0] e_src, e_dst;

    always #2 clk = ~clk;

    wtp_token_parser u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_tok(input int idx, input logic [24:0] v);
        return {1'b1, 1'b0, 5'(idx), v};
    endfunction

    function automatic logic [31:0] dat_tok(input logic crun, input logic [29:0] v);
        return {1'b0, crun, v};
    endfunction

    task automatic send(input logic [31:0] t);
        @(negedge clk);
        while (!tok_ready) @(negedge clk);
        tok_valid = 1'b1;
        tok_data  = t;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic check_and_take(input string req);
        chk({req, " job_valid"}, 64'(job_valid), 64'd1);
        chk({req, " R8 tok_ready low"}, 64'(tok_ready), 64'd0);
        chk({req, " quad"}, 64'(job_quad), 64'(e_quad));
        chk({req, " R6 crun"}, 64'(job_crun), 64'(e_crun));
        chk({req, " R6 interp"}, 64'(job_interp), 64'(e_interp));
        chk({req, " R6 scan"}, 64'(job_scan), 64'(e_scan));
        chk({req, " frx"}, 64'(job_frx), 64'(e_frx));
        chk({req, " ipx"}, 64'(job_ipx), 64'(e_ipx));
        chk({req, " fry"}, 64'(job_fry), 64'(e_fry));
        for (int c = 0; c < 4; c++) begin
            chk({req, " cx"}, 64'(job_cx[c]), 64'(e_cx[c]));
            chk({req, " cy"}, 64'(job_cy[c]), 64'(e_cy[c]));
        end
        chk({req, " src"}, 64'(job_src), 64'(e_src));
        chk({req, " dst"}, 64'(job_dst), 64'(e_dst));
        job_ready = 1'b1;
        @(negedge clk);
        job_ready = 1'b0;
        chk({req, " R8 job taken"}, 64'(job_valid), 64'd0);
    endtask

    // Scaling job with the expected values it implies
    task automatic scale_job(input int k, input logic cr);
        e_quad = 1'b0; e_crun = cr;
        e_frx = 10'((k * 37 + 5) & 'h3FF);
        e_ipx = 6'((k * 11 + 3) & 'h3F);
        e_fry = 10'((k * 53 + 1) & 'h3FF);
        for (int c = 0; c < 4; c++) begin e_cx[c] = '0; e_cy[c] = '0; end
        e_src = 30'(k * 32'h0123_4567 + 9);
        e_dst = 30'(k * 32'h0765_4321 + 2);
        send(dat_tok(cr, {4'b0, e_fry, e_ipx, e_frx}));
        send(dat_tok(1'b0, e_src));
        send(dat_tok(1'b0, e_dst));
    endtask

    // Quadrilateral job with the expected values it implies
    task automatic quad_job(input int k, input logic cr);
        e_quad = 1'b1; e_crun = cr;
        e_frx = '0; e_ipx = '0; e_fry = '0;
        for (int c = 0; c < 4; c++) begin
            e_cx[c] = 30'(k * 32'h0011_0101 + c * 32'h0300_0007 + 1);
            e_cy[c] = 30'(k * 32'h0022_0203 + c * 32'h0500_000B + 4);
        end
        e_src = 30'(k * 32'h0345_6789 + 17);
        e_dst = 30'(k * 32'h0987_6543 + 21);
        for (int c = 0; c < 4; c++) begin
            send(dat_tok(c == 0 ? cr : 1'b0, e_cx[c]));
            send(dat_tok(1'b0, e_cy[c]));
        end
        send(dat_tok(1'b0, e_src));
        send(dat_tok(1'b0, e_dst));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tok_valid = 1'b0; tok_data = '0; job_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk("R2 job_valid", 64'(job_valid), 64'd0);
        chk("R2 proto_err", 64'(proto_err), 64'd0);
        chk("R2 tok_ready", 64'(tok_ready), 64'd1);
        for (int i = 0; i < 32; i++) chk("R2 cfg reg zero", 64'(cfg_q[i]), 64'd0);

        // R1: write every register and read each back
        for (int i = 0; i < 32; i++) begin
            logic [24:0] v;
            v = 25'(i * 32'h0013_579B + 7);
            send(cfg_tok(i, v));
            chk("R1 cfg write", 64'(cfg_q[i]), 64'(v));
            chk("R1 no job", 64'(job_valid), 64'd0);
        end
        for (int i = 0; i < 32; i++)
            chk("R1 cfg retained", 64'(cfg_q[i]), 64'(25'(i * 32'h0013_579B + 7)));

        // R3 R6: scaling sweep over interp, scan and run flag
        send(cfg_tok(26, 25'h1FF_FFFE));
        for (int it = 0; it < 4; it++) begin
            for (int sc = 0; sc < 2; sc++) begin
                for (int cr = 0; cr < 2; cr++) begin
                    int k;
                    k = it * 4 + sc * 2 + cr;
                    send(cfg_tok(24, 25'(it | (k << 4))));
                    send(cfg_tok(25, 25'(sc | (k << 2))));
                    e_interp = 2'(it); e_scan = 1'(sc);
                    scale_job(k, 1'(cr));
                    check_and_take("R3 scaling");
                end
            end
        end

        // R4: quadrilateral jobs
        send(cfg_tok(26, 25'd1));
        send(cfg_tok(24, 25'd2));
        send(cfg_tok(25, 25'd1));
        e_interp = 2'd2; e_scan = 1'b1;
        for (int k = 0; k < 4; k++) begin
            quad_job(k, 1'(k & 1));
            check_and_take("R4 quad");
        end
        chk("R9 no error between jobs", 64'(proto_err), 64'd0);

        // R8: back-pressure with a configure token waiting
        scale_job(40, 1'b0);  // mode is quad: start fresh as scaling below
        send(cfg_tok(26, 25'd0)); // aborts partial quad job (3 tokens in)
        chk("R7 error raised", 64'(proto_err), 64'd1);
        e_interp = 2'd2; e_scan = 1'b1;
        scale_job(41, 1'b1);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_data  = cfg_tok(3, 25'h0AB_CDEF);
        repeat (3) begin
            @(negedge clk);
            chk("R8 held valid", 64'(job_valid), 64'd1);
            chk("R8 held src", 64'(job_src), 64'(e_src));
            chk("R8 stalled token not written", 64'(cfg_q[3]), 64'(25'(3 * 32'h0013_579B + 7)));
        end
        check_and_take("R8 held job");
        @(negedge clk);
        tok_valid = 1'b0;
        chk("R8 token taken after release", 64'(cfg_q[3]), 64'h0AB_CDEF);

        // R5 R7: abort a quad job at every position, then a scaling job
        for (int p = 1; p < 10; p++) begin
            send(cfg_tok(26, 25'd1));
            for (int j = 0; j < p; j++) send(dat_tok(1'b1, 30'(j + 100)));
            send(cfg_tok(26, 25'd0));
            chk("R7 abort no job", 64'(job_valid), 64'd0);
            chk("R9 error stays", 64'(proto_err), 64'd1);
            chk("R7 write applied", 64'(cfg_q[26]), 64'd0);
            scale_job(50 + p, 1'b0);
            check_and_take("R5 R7 fresh scaling after abort");
        end
        // abort a scaling job at each position, then a quad job
        for (int p = 1; p < 3; p++) begin
            send(cfg_tok(26, 25'd0));
            for (int j = 0; j < p; j++) send(dat_tok(1'b0, 30'(j + 7)));
            send(cfg_tok(26, 25'd1));
            chk("R7 abort no job", 64'(job_valid), 64'd0);
            quad_job(70 + p, 1'b1);
            check_and_take("R5 R7 fresh quad after abort");
        end
        chk("R9 error still set", 64'(proto_err), 64'd1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule